// File: doc/BRIEF.md
# Sleep Mode Sequencer

This block sequences the low-power states of a small 8-bit processor core. The core raises a one-cycle sleep strobe when it executes its sleep operation. The block enters a low-power state only if the sleep-enable bit is set in the same cycle. The mode is taken from three select bits that sit in three different control registers. The block latches that mode on entry. While the core sleeps, the block drives enables for the CPU clock, for the remaining peripheral clocks and for the oscillator.

Two events end a sleep. A pending enabled interrupt, sampled only in the sleep state, starts a wake sequence. The core is held halted through a mode-dependent start-up delay plus four further cycles. A one-cycle resume indication then tells the core to service the interrupt and to continue after its sleep operation; the block leaves the program counter alone. A reset request in any state returns the block to run at once and pulses a restart indication instead of a resume. The block drives no clear or reset toward the register file or SRAM.

Top module: `pwr_sleep_seq`

## Requirements
- R1: A sleep strobe enters sleep, with `halt_o` high one cycle later, only when `ctl_main[5]` is 1 in the same cycle. With that bit at 0 the strobe has no effect and `halt_o` stays 0.
- R2: The select code is {`ctl_stat[5]`, `ctl_main[4]`, `ctl_ext[SM0_BIT]`} with SM0_BIT = 7 by default. 000 selects Idle, 010 Power-down and 110 Standby. All other register bits are ignored.
- R3: In Idle sleep, `cpu_clk_en` = 0, `io_clk_en` = 1 and `osc_en` = 1.
- R4: In Power-down sleep, `cpu_clk_en`, `io_clk_en` and `osc_en` are all 0.
- R5: In Standby sleep, `cpu_clk_en` = 0, `io_clk_en` = 0 and `osc_en` = 1.
- R6: The codes 001, 011, 100, 101 and 111 behave as Idle.
- R7: Wake is taken only from sleep. `irq_pend` while running has no effect. Without `irq_pend` or `rst_req` the block stays asleep.
- R8: After `irq_pend` is sampled in sleep, `halt_o` stays 1 for exactly S+4 cycles. S is IDLE_START (1), PD_START (20) or SB_START (6), chosen by the latched mode. In the next cycle `resume_o` = 1, `halt_o` = 0 and `cpu_clk_en` = 1, for one cycle only.
- R9: `rst_req` in any state gives, one cycle later, `restart_o` = 1 for one cycle, `halt_o` = 0, all enables 1 and no `resume_o`.
- R10: After `rst_n` reset, `halt_o`, `resume_o` and `restart_o` are 0 and all three enables are 1.
- R11: A sleep strobe while halted is ignored. It does not change the wake timing, and the block returns to run after the resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_op | input | 1 | One-cycle strobe from the core's sleep operation |
| ctl_main | input | 8 | Main control register value (enable at bit 5, select bit 1 at bit 4) |
| ctl_stat | input | 8 | Control/status register value (select bit 2 at bit 5) |
| ctl_ext | input | 8 | Extended control register value (select bit 0 at SM0_BIT) |
| irq_pend | input | 1 | An enabled interrupt is pending |
| rst_req | input | 1 | Reset request from the reset logic |
| halt_o | output | 1 | Core held halted |
| cpu_clk_en | output | 1 | CPU clock enable |
| io_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| resume_o | output | 1 | One-cycle pulse: service interrupt, then continue after the sleep operation |
| restart_o | output | 1 | One-cycle pulse: restart from the reset vector |

## Verification
Sleep entry and the clock-enable pattern for the mode appear one cycle after the strobe. The bench drives stimulus at the falling edge and samples at the next falling edge.

For a wake, the bench counts the falling edges at which `halt_o` is still high, starting one cycle after the interrupt. That count must equal S+4, and `resume_o` must be high at the first sample where the halt has dropped. A reset request is checked one cycle after it is raised, and again one cycle after that to confirm the restart pulse is a single cycle.

// File: rtl/pwr_sleep_seq.sv
module pwr_sleep_seq #(
  parameter int IDLE_START = 1,
  parameter int SB_START   = 6,
  parameter int PD_START   = 20,
  parameter int SM0_BIT    = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_op,
  input  logic [7:0] ctl_main,
  input  logic [7:0] ctl_stat,
  input  logic [7:0] ctl_ext,
  input  logic       irq_pend,
  input  logic       rst_req,
  output logic       halt_o,
  output logic       cpu_clk_en,
  output logic       io_clk_en,
  output logic       osc_en,
  output logic       resume_o,
  output logic       restart_o
);
  localparam int HALT_CYC = 4;
  localparam int MAXS = (PD_START > SB_START) ?
                        ((PD_START > IDLE_START) ? PD_START : IDLE_START) :
                        ((SB_START > IDLE_START) ? SB_START : IDLE_START);
  localparam int CW = $clog2(MAXS + HALT_CYC + 1) + 1;

  typedef enum logic [2:0] {S_RUN, S_SLEEP, S_STARTUP, S_HALT4, S_RESUME} st_t;
  typedef enum logic [1:0] {M_IDLE, M_PD, M_SB} mode_t;

  st_t           st;
  mode_t         mode_q, mode_d;
  logic [CW-1:0] cnt, lim;
  logic          restart_q;

  wire [2:0] code = {ctl_stat[5], ctl_main[4], ctl_ext[SM0_BIT]};
  wire       sleep_en = ctl_main[5];
  wire       unused_regs = ^{ctl_main & 8'hCF, ctl_stat & 8'hDF,
                             ctl_ext & ~(8'd1 << SM0_BIT)};

  assign mode_d = (code == 3'b010) ? M_PD :
                  (code == 3'b110) ? M_SB : M_IDLE;

  assign lim = (mode_q == M_PD) ? CW'(PD_START) :
               (mode_q == M_SB) ? CW'(SB_START) : CW'(IDLE_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_RUN;
      mode_q    <= M_IDLE;
      cnt       <= '0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= rst_req;
      if (rst_req) begin
        st  <= S_RUN;
        cnt <= '0;
      end else begin
        case (st)
          S_RUN: if (sleep_op && sleep_en) begin
            st     <= S_SLEEP;
            mode_q <= mode_d;
          end
          S_SLEEP: if (irq_pend) begin
            st  <= S_STARTUP;
            cnt <= '0;
          end
          S_STARTUP: begin
            if (cnt == lim - 1'b1) begin
              st  <= S_HALT4;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_HALT4: begin
            if (cnt == CW'(HALT_CYC - 1)) begin
              st  <= S_RESUME;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_RUN;
        endcase
      end
    end
  end

  assign halt_o     = (st == S_SLEEP) || (st == S_STARTUP) || (st == S_HALT4);
  assign cpu_clk_en = (st == S_RUN) || (st == S_RESUME);
  assign io_clk_en  = !((st == S_SLEEP) || (st == S_STARTUP)) || (mode_q == M_IDLE);
  assign osc_en     = !((st == S_SLEEP) && (mode_q == M_PD));
  assign resume_o   = (st == S_RESUME);
  assign restart_o  = restart_q;
endmodule

// File: rtl/pwr_sleep_seq_chk.sv
module pwr_sleep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_op,
  input logic [7:0] ctl_main,
  input logic       irq_pend,
  input logic       rst_req,
  input logic       halt_o,
  input logic       cpu_clk_en,
  input logic       io_clk_en,
  input logic       osc_en,
  input logic       resume_o,
  input logic       restart_o,
  input logic [2:0] st
);
  a_r1_no_entry_without_se: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && sleep_op && !ctl_main[5] && !rst_req) |=> !halt_o);
  a_r4_pd_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !osc_en) |-> (!io_clk_en && !cpu_clk_en));
  a_r7_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && !irq_pend && !rst_req) |=> halt_o);
  a_r8_cpu_gated_while_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !cpu_clk_en);
  a_r8_release_via_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(halt_o) && !restart_o) |-> resume_o);
  a_r8_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);
  a_r9_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (restart_o && !halt_o && !resume_o));
endmodule

bind pwr_sleep_seq pwr_sleep_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op), .ctl_main(ctl_main),
  .irq_pend(irq_pend), .rst_req(rst_req), .halt_o(halt_o),
  .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .osc_en(osc_en),
  .resume_o(resume_o), .restart_o(restart_o), .st(st)
);

// File: tb/pwr_sleep_seq_bench.sv
module pwr_sleep_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_op = 1'b0, irq_pend = 1'b0, rst_req = 1'b0;
  logic [7:0] ctl_main = 8'h00, ctl_stat = 8'h00, ctl_ext = 8'h00;
  logic halt_o, cpu_clk_en, io_clk_en, osc_en, resume_o, restart_o;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pwr_sleep_seq u_pwr_sleep_seq (
    .clk(clk), .rst_n(rst_n), .sleep_op(sleep_op), .ctl_main(ctl_main),
    .ctl_stat(ctl_stat), .ctl_ext(ctl_ext), .irq_pend(irq_pend),
    .rst_req(rst_req), .halt_o(halt_o), .cpu_clk_en(cpu_clk_en),
    .io_clk_en(io_clk_en), .osc_en(osc_en), .resume_o(resume_o),
    .restart_o(restart_o)
  );

  // main, stat, ext, expected {cpu,io,osc} asleep, start-up cycles
  localparam logic [34:0] VEC [0:7] = '{
    {8'h20, 8'h00, 8'h00, 3'b011, 8'd1},
    {8'h30, 8'h00, 8'h00, 3'b000, 8'd20},
    {8'h30, 8'h20, 8'h00, 3'b001, 8'd6},
    {8'h20, 8'h00, 8'h80, 3'b011, 8'd1},
    {8'h30, 8'h00, 8'h80, 3'b011, 8'd1},
    {8'h20, 8'h20, 8'h00, 3'b011, 8'd1},
    {8'h30, 8'h20, 8'h7F, 3'b001, 8'd6},
    {8'h3F, 8'hDF, 8'h00, 3'b000, 8'd20}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enter(input logic [7:0] m, input logic [7:0] s, input logic [7:0] e);
    ctl_main = m; ctl_stat = s; ctl_ext = e; sleep_op = 1'b1;
    @(negedge clk);
    sleep_op = 1'b0;
  endtask

  task automatic wake_and_count(output int n);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    n = 0;
    while (halt_o && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=done");
    total++; bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset outputs", {halt_o, resume_o, restart_o, cpu_clk_en, io_clk_en, osc_en}, 6'b000111);

    for (int i = 0; i < 8; i++) begin
      enter(VEC[i][34:27], VEC[i][26:19], VEC[i][18:11]);
      check($sformatf("R1 entry vec%0d", i), halt_o, 1);
      check($sformatf("R2/R3/R4/R5/R6 enables vec%0d", i), {cpu_clk_en, io_clk_en, osc_en}, VEC[i][10:8]);
      wake_and_count(n);
      check($sformatf("R8 halt length vec%0d", i), n, VEC[i][7:0] + 4);
      check($sformatf("R8 resume vec%0d", i), {resume_o, cpu_clk_en}, 2'b11);
      @(negedge clk);
      check($sformatf("R8 resume single vec%0d", i), {resume_o, halt_o}, 2'b00);
    end

    enter(8'h10, 8'h00, 8'h00);
    check("R1 strobe without enable", halt_o, 0);
    repeat (2) @(negedge clk);
    check("R1 still running", {halt_o, cpu_clk_en}, 2'b01);

    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    @(negedge clk);
    check("R7 irq while running", {halt_o, resume_o}, 2'b00);

    enter(8'h20, 8'h00, 8'h00);
    repeat (10) @(negedge clk);
    check("R7 stays asleep without wake", halt_o, 1);
    wake_and_count(n);
    check("R7 late wake length", n, 5);

    @(negedge clk);
    enter(8'h30, 8'h00, 8'h00);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    check("R9 reset in sleep", {restart_o, halt_o, resume_o, cpu_clk_en, io_clk_en, osc_en}, 6'b100111);
    @(negedge clk);
    check("R9 restart single", {restart_o, resume_o, halt_o}, 3'b000);

    enter(8'h30, 8'h00, 8'h00);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    check("R9 reset in start-up", {restart_o, halt_o, resume_o}, 3'b100);
    repeat (30) @(negedge clk);
    check("R9 no resume later", {resume_o, halt_o}, 2'b00);

    enter(8'h30, 8'h20, 8'h00);
    irq_pend = 1'b1;
    @(negedge clk);
    irq_pend = 1'b0;
    sleep_op = 1'b1;
    n = 1;
    @(negedge clk);
    sleep_op = 1'b0;
    while (halt_o && n < 200) begin
      n++;
      @(negedge clk);
    end
    check("R11 strobe while halted timing", n, 10);
    @(negedge clk);
    check("R11 back to run", {halt_o, cpu_clk_en}, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule